// File: doc/BRIEF.md
# Two-Channel Register-Programmed Pulse Generator

This block drives two independent pulse-width-modulated outputs. Software programs it through a small 32-bit register port with an address, write data, a write strobe and a registered read-data bus. Each channel has a period and a high-time (duty) value, both counted in cycles of the block's own clock. A single shared control word holds one 8-bit lane per channel, and each lane starts or stops the channel and can invert its output.

Each channel keeps an internal counter that runs from zero up to the period minus one and then wraps. The output is at its active level while the counter is below the duty value. New period and duty values move into the channel's working copy only when the counter wraps, or at once while the channel is stopped. This means a running waveform never shows a period that is partly old and partly new.

The register port has no handshake. A write is taken on every clock edge where the strobe is high, and nothing stalls the bus, so no back-pressure exists. Read data is registered: it shows the register selected in the previous cycle, with the contents it held before any write in that same cycle.

Top module: `pwm_dual_top`

## Requirements
- R1: While reset is asserted and right after it, every register reads as zero and both outputs are 0.
- R2: Byte address 0x00 is the control word. Channel n's period is at 0x10 + 0x10*n and its duty at 0x14 + 0x10*n. Every register is 32 bits wide and reads back its last written value. Read data appears one cycle after the address is presented and shows the contents from before a write in that same cycle.
- R3: A read from any other address returns zero. A write to any other address changes no register.
- R4: Channel n owns control bits [8n+7:8n]. In that lane, bit 0 is enable, bit 4 is invert and bit 7 is mode. A channel runs only when both enable and mode are 1. The other lane bits are stored and read back but have no effect.
- R5: While a channel is not running, its counter is held at zero and its output equals its invert bit.
- R6: While a channel is running with a working period P ≥ 2, the counter steps 0,1,…,P-1 and then repeats. The output equals (count < duty) XOR invert.
- R7: A working duty of 0 gives a constant inactive level. A working duty ≥ the working period gives a constant active level.
- R8: A working period below 2 keeps a running channel at its inactive level.
- R9: Register period and duty values are copied to the working values on the edge where the counter is at P-1, or when the working period is below 2, or on any edge while the channel is stopped. At all other times the working values hold.
- R10: A change of the invert bit shows on the output in the cycle after the write, with no effect on the counter.
- R11: The two channels share no state apart from the control word. Programming one channel leaves the other channel's waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; also the count unit |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 8 | Byte address of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_we_i | input | 1 | Write strobe, one write per high cycle |
| reg_rdata_o | output | 32 | Registered read data for the previous cycle's address |
| pwm_o | output | 2 | Pulse outputs, bit n for channel n |

## Verification
Two events can fall in the same cycle: a software write to a period or duty register, and the counter wrap that copies those registers into the working values. The bench provokes this by rewriting the duty and period values at several phases of a running waveform, so that some writes land on the wrap edge. In that case the wrap must take the value from before the write, and the new value must wait a full period. A read and a write to the same address in one cycle are also provoked, and the read must return the old contents. A behavioural model checks both outcomes against the outputs on every clock.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;
  localparam int unsigned NUM_CH     = 2;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned LANE_W     = 8;
  localparam int unsigned BIT_EN     = 0;
  localparam int unsigned BIT_INV    = 4;
  localparam int unsigned BIT_MODE   = 7;
  localparam int unsigned CTRL_ADDR  = 'h00;
  localparam int unsigned CH_BASE    = 'h10;
  localparam int unsigned CH_STRIDE  = 'h10;
  localparam int unsigned DUTY_OFS   = 'h4;
  localparam int unsigned MIN_PERIOD = 2;

  typedef struct packed {
    logic run;
    logic inv;
  } lane_cfg_t;
endpackage

// File: rtl/pwm_dual_regs.sv
module pwm_dual_regs
  import pwm_dual_pkg::*;
#(
  parameter int unsigned N_CH = NUM_CH,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned AW   = ADDR_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             wdata_i,
  input  logic                      we_i,
  output logic [DW-1:0]             rdata_o,
  output logic [DW-1:0]             ctrl_o,
  output logic [N_CH-1:0][DW-1:0]   per_o,
  output logic [N_CH-1:0][DW-1:0]   duty_o
);
  logic              hit_ctrl;
  logic [N_CH-1:0]   hit_per;
  logic [N_CH-1:0]   hit_duty;
  logic [DW-1:0]     ctrl_q;
  logic [N_CH-1:0][DW-1:0] per_q;
  logic [N_CH-1:0][DW-1:0] duty_q;
  logic [DW-1:0]     rd_mux;
  logic [DW-1:0]     rdata_q;

  assign hit_ctrl = (addr_i == AW'(CTRL_ADDR));

  for (genvar c = 0; c < N_CH; c++) begin : g_dec
    localparam int unsigned PER_A  = CH_BASE + CH_STRIDE * c;
    localparam int unsigned DUTY_A = PER_A + DUTY_OFS;
    assign hit_per[c]  = (addr_i == AW'(PER_A));
    assign hit_duty[c] = (addr_i == AW'(DUTY_A));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        per_q[c]  <= '0;
        duty_q[c] <= '0;
      end else if (we_i) begin
        if (hit_per[c])  per_q[c]  <= wdata_i;
        if (hit_duty[c]) duty_q[c] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ctrl_q <= '0;
    else if (we_i && hit_ctrl)  ctrl_q <= wdata_i;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) rd_mux = ctrl_q;
    for (int c = 0; c < N_CH; c++) begin
      if (hit_per[c])  rd_mux = per_q[c];
      if (hit_duty[c]) rd_mux = duty_q[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign ctrl_o  = ctrl_q;
  assign per_o   = per_q;
  assign duty_o  = duty_q;
endmodule

// File: rtl/pwm_dual_channel.sv
module pwm_dual_channel
  import pwm_dual_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned MIN_P = MIN_PERIOD
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  lane_cfg_t     cfg_i,
  input  logic [DW-1:0] per_reg_i,
  input  logic [DW-1:0] duty_reg_i,
  output logic          pwm_o,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] per_act_o,
  output logic [DW-1:0] duty_act_o
);
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] per_a_q;
  logic [DW-1:0] duty_a_q;
  logic          per_ok;
  logic          at_wrap;
  logic          active;

  assign per_ok  = (per_a_q >= DW'(MIN_P));
  assign at_wrap = !per_ok || (cnt_q == per_a_q - DW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      per_a_q  <= '0;
      duty_a_q <= '0;
    end else if (!cfg_i.run || at_wrap) begin
      cnt_q    <= '0;
      per_a_q  <= per_reg_i;
      duty_a_q <= duty_reg_i;
    end else begin
      cnt_q    <= cnt_q + DW'(1);
    end
  end

  assign active     = cfg_i.run && per_ok && (cnt_q < duty_a_q);
  assign pwm_o      = active ^ cfg_i.inv;
  assign cnt_o      = cnt_q;
  assign per_act_o  = per_a_q;
  assign duty_act_o = duty_a_q;
endmodule

// File: rtl/pwm_dual_top.sv
module pwm_dual_top
  import pwm_dual_pkg::*;
#(
  parameter int unsigned N_CH = NUM_CH,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned AW   = ADDR_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  input  logic            reg_we_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic [N_CH-1:0] pwm_o
);
  logic [DW-1:0]           ctrl_w;
  logic [N_CH-1:0][DW-1:0] per_w;
  logic [N_CH-1:0][DW-1:0] duty_w;
  logic [N_CH-1:0][DW-1:0] cnt_w;
  logic [N_CH-1:0][DW-1:0] pera_w;
  logic [N_CH-1:0][DW-1:0] dutya_w;

  pwm_dual_regs #(.N_CH(N_CH), .DW(DW), .AW(AW)) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .we_i    (reg_we_i),
    .rdata_o (reg_rdata_o),
    .ctrl_o  (ctrl_w),
    .per_o   (per_w),
    .duty_o  (duty_w)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    lane_cfg_t cfg;
    assign cfg.run = ctrl_w[c*LANE_W + BIT_EN] && ctrl_w[c*LANE_W + BIT_MODE];
    assign cfg.inv = ctrl_w[c*LANE_W + BIT_INV];

    pwm_dual_channel #(.DW(DW)) ch_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_i      (cfg),
      .per_reg_i  (per_w[c]),
      .duty_reg_i (duty_w[c]),
      .pwm_o      (pwm_o[c]),
      .cnt_o      (cnt_w[c]),
      .per_act_o  (pera_w[c]),
      .duty_act_o (dutya_w[c])
    );
  end
endmodule

// File: rtl/pwm_dual_chk.sv
module pwm_dual_chk
  import pwm_dual_pkg::*;
#(
  parameter int unsigned N_CH = NUM_CH,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned AW   = ADDR_W
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [AW-1:0]           reg_addr_i,
  input logic [DW-1:0]           reg_rdata_o,
  input logic [DW-1:0]           ctrl_w,
  input logic [N_CH-1:0][DW-1:0] cnt_w,
  input logic [N_CH-1:0][DW-1:0] pera_w,
  input logic [N_CH-1:0][DW-1:0] dutya_w,
  input logic [N_CH-1:0]         pwm_o
);
  function automatic logic is_mapped(input logic [AW-1:0] a);
    logic m;
    m = (a == AW'(0));
    for (int c = 0; c < N_CH; c++) begin
      if (a == AW'(16 + 16 * c)) m = 1'b1;
      if (a == AW'(20 + 16 * c)) m = 1'b1;
    end
    return m;
  endfunction

  // R3: unmapped addresses read as zero on the following cycle
  p_unmapped_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_mapped(reg_addr_i) |=> (reg_rdata_o == '0));

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    logic run, inv;
    assign run = ctrl_w[c*8] && ctrl_w[c*8 + 7];
    assign inv = ctrl_w[c*8 + 4];

    p_idle_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run |-> (pwm_o[c] == inv));

    p_count_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && pera_w[c] >= DW'(2)) |-> (cnt_w[c] < pera_w[c]));

    p_zero_duty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && dutya_w[c] == '0) |-> (pwm_o[c] == inv));

    p_short_period_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && pera_w[c] < DW'(2)) |-> (pwm_o[c] == inv));

    p_hold_midperiod_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && $past(run) && cnt_w[c] != '0) |-> ($stable(pera_w[c]) && $stable(dutya_w[c])));
  end
endmodule

bind pwm_dual_top pwm_dual_chk #(.N_CH(N_CH), .DW(DW), .AW(AW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .ctrl_w      (ctrl_w),
  .cnt_w       (cnt_w),
  .pera_w      (pera_w),
  .dutya_w     (dutya_w),
  .pwm_o       (pwm_o)
);

// File: tb/pwm_dual_top_tb_top.sv
module pwm_dual_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [1:0]  pwm;

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_req  = "R1";

  always #4 clk = ~clk;

  pwm_dual_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_we_i(we), .reg_rdata_o(rdata), .pwm_o(pwm)
  );

  // behavioural reference
  logic [31:0] m_ctrl = '0;
  logic [31:0] m_per [2] = '{0, 0};
  logic [31:0] m_duty[2] = '{0, 0};
  longint      m_cnt [2] = '{0, 0};
  longint      m_pa  [2] = '{0, 0};
  longint      m_da  [2] = '{0, 0};
  logic [31:0] m_rd  = '0;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == 8'h00) return m_ctrl;
    if (a == 8'h10) return m_per[0];
    if (a == 8'h14) return m_duty[0];
    if (a == 8'h20) return m_per[1];
    if (a == 8'h24) return m_duty[1];
    return '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0; m_rd = '0;
      for (int c = 0; c < 2; c++) begin
        m_per[c] = '0; m_duty[c] = '0; m_cnt[c] = 0; m_pa[c] = 0; m_da[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit run;
        run = m_ctrl[c*8] && m_ctrl[c*8+7];
        if (!run || m_pa[c] < 2 || m_cnt[c] == m_pa[c] - 1) begin
          m_cnt[c] = 0; m_pa[c] = longint'(m_per[c]); m_da[c] = longint'(m_duty[c]);
        end else m_cnt[c] = m_cnt[c] + 1;
      end
      m_rd = m_read(addr);
      if (we) begin
        case (addr)
          8'h00: m_ctrl = wdata;
          8'h10: m_per[0] = wdata;
          8'h14: m_duty[0] = wdata;
          8'h20: m_per[1] = wdata;
          8'h24: m_duty[1] = wdata;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      bit run, exp;
      run = m_ctrl[c*8] && m_ctrl[c*8+7];
      exp = (run && m_pa[c] >= 2 && m_cnt[c] < m_da[c]) ^ m_ctrl[c*8+4];
      n_checks++;
      if (pwm[c] !== exp) begin
        n_fails++;
        $display("FAIL %s pwm[%0d] actual=%b expected=%b t=%0t", cur_req, c, pwm[c], exp, $time);
      end
    end
    n_checks++;
    if (rdata !== m_rd) begin
      n_fails++;
      $display("FAIL %s rdata actual=%h expected=%h t=%0t", cur_req, rdata, m_rd, $time);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #800_000;
    n_fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    cur_req = "R1"; idle(3); rst_n = 1'b1;
    rd(8'h00); rd(8'h10); rd(8'h24);
    cur_req = "R2";
    wr(8'h10, 32'hDEAD_BEEF); wr(8'h14, 32'h1234_5678);
    wr(8'h20, 32'hA5A5_0001); wr(8'h24, 32'h0F0F_F0F0);
    wr(8'h00, 32'h5A00_6C2E);
    rd(8'h10); rd(8'h14); rd(8'h20); rd(8'h24); rd(8'h00);
    // read and write to the same address in one cycle returns old contents
    @(negedge clk); addr = 8'h10; wdata = 32'h0000_0005; we = 1'b1;
    @(negedge clk); we = 1'b0; rd(8'h10);
    cur_req = "R3";
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h30, 32'hFFFF_FFFF); wr(8'h11, 32'h1);
    wr(8'hFC, 32'h7);
    rd(8'h04); rd(8'h30); rd(8'h18); rd(8'h10); rd(8'h00);
    cur_req = "R5";
    wr(8'h00, 32'h0000_0000); wr(8'h14, 32'd2);
    wr(8'h00, 32'h0000_0001); idle(8);   // enable without mode
    wr(8'h00, 32'h0000_0090); idle(8);   // mode+invert without enable
    cur_req = "R6";
    wr(8'h00, 32'h0000_0081); idle(20);
    cur_req = "R10";
    wr(8'h00, 32'h0000_0091); idle(13);
    wr(8'h00, 32'h0000_0081); idle(7);
    cur_req = "R9";
    for (int k = 0; k < 6; k++) begin
      wr(8'h14, 32'(k % 4)); idle(k);
      wr(8'h10, 32'(3 + k % 3)); idle(2);
    end
    idle(12);
    cur_req = "R7";
    wr(8'h14, 32'd0); idle(14);
    wr(8'h14, 32'd9); idle(14);
    wr(8'h10, 32'd4); wr(8'h14, 32'd4); idle(12);
    cur_req = "R8";
    wr(8'h10, 32'd1); idle(10);
    wr(8'h10, 32'd0); wr(8'h00, 32'h0000_0091); idle(10);
    wr(8'h10, 32'd6); wr(8'h14, 32'd3); idle(15);
    cur_req = "R11";
    wr(8'h20, 32'd7); wr(8'h24, 32'd3);
    wr(8'h00, 32'h0000_9181); idle(25);
    wr(8'h24, 32'd5); wr(8'h10, 32'd3); idle(25);
    wr(8'h00, 32'h0000_8101); idle(20);
    cur_req = "R4";
    wr(8'h00, 32'h00FF_6E81); idle(15); rd(8'h00);
    wr(8'h00, 32'h0000_0000); idle(6);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule